// File: doc/BRIEF.md
# Packet-Mode Dual-Clock Capture Buffer

This block sits between a converter that produces 32-bit measurements and a consumer that takes 16-bit words. It works in whole packets. On the write clock it collects one packet of measurements and stores each one as two 16-bit words, upper half first. Once the packet is complete it stops accepting data. On the read clock it waits a short settling time and then presents the stored words to the consumer until the storage is empty. Only after the write side sees the storage empty again does it open for the next packet. Each packet therefore leaves the block as one unbroken burst.

The write and read sides run on unrelated clocks. Each pointer crosses to the other side as Gray code through two flops. The packet boundary comes from the occupancy level, worked out in each domain from its own pointer and the synchronized copy of the other. There is no separate measurement counter that could drift from what was actually stored.

The write input has no back-pressure. A measurement is taken on any write cycle where `meas_valid` is high while the block is accepting. Measurements arriving at any other time are discarded whole and recorded in a sticky flag. Measurements must therefore be spaced at least two write cycles apart. The read output follows valid/ready rules:
- a word transfers on a read cycle where `rd_valid` and `rd_ready` are both high;
- while `rd_valid` is high and `rd_ready` is low, the word and `rd_valid` stay put;
- `rd_valid` never depends on `rd_ready`.

Top module: `pkt_capture_buffer`

## Requirements
- R1: Storage holds 2*PKT_MEAS words of WORD_W bits, which is exactly one packet. Each accepted measurement is read out as two words: bits [2*WORD_W-1:WORD_W] first, then bits [WORD_W-1:0].
- R2: Within a packet, words leave in the order their measurements were accepted, with no loss and no repetition.
- R3: A measurement is accepted only in a write cycle where the block is filling and no lower half is waiting to be stored. The lower half is stored in the following write cycle. A measurement presented in that following cycle is dropped whole, and neither half is stored.
- R4: Filling stops as soon as 2*PKT_MEAS words are held. Any measurement offered after that is dropped, so a packet never grows beyond that size.
- R5: Filling of a new packet begins only after the write side sees the storage empty. After write reset it begins once the empty storage is seen. Measurements offered while a packet is draining are dropped.
- R6: `rd_valid` first rises right after the fifth rising read-clock edge that follows the write-clock edge storing the last word of a packet. That delay is two synchronizer stages, one detection cycle and two settling cycles.
- R7: Once started, reading continues while any word remains. `rd_valid` falls after the last word is taken. A partly filled packet is never presented.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` holds its value.
- R9: `meas_dropped` goes high after the first dropped measurement and stays high until write reset.
- R10: Write reset (`wr_rst`, active high, synchronous) clears the write pointer and `meas_dropped`, and returns the write side to waiting for empty. Read reset (`rd_rst`) clears the read pointer and holds `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| meas_valid | input | 1 | Measurement strobe |
| meas_data | input | 2*WORD_W | Measurement; upper half stored first |
| meas_dropped | output | 1 | Sticky flag: a measurement was discarded |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_valid | output | 1 | Output word available |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | WORD_W | Output word |

## Verification
The bench builds the block with WORD_W=16 and PKT_MEAS=4. This gives an eight-word store and four-bit pointers, so every packet fills and drains in a few dozen cycles. Running five packets wraps both pointers more than once, which exercises the Gray-code crossing and the wrap-around of the level arithmetic. The short packet also makes it cheap to reach a complete packet that is followed by a surplus measurement, a measurement offered during the drain, and a back-to-back strobe pair. The read consumer runs in four modes: always ready, alternating, pseudo-random, and long stalls.

// File: rtl/pkt_cap_pkg.sv
`timescale 1ns/1ps
package pkt_cap_pkg;
  typedef enum logic {
    W_WAIT_EMPTY = 1'b0,
    W_FILL       = 1'b1
  } wr_state_e;

  typedef enum logic [1:0] {
    R_IDLE  = 2'd0,
    R_SETL1 = 2'd1,
    R_SETL2 = 2'd2,
    R_DRAIN = 2'd3
  } rd_state_e;
endpackage

// File: rtl/pkt_ptr_cross.sv
`timescale 1ns/1ps
// Two-flop capture of a Gray pointer in the destination domain, then
// conversion back to binary for level arithmetic.
module pkt_ptr_cross #(
  parameter int PW = 11
) (
  input  logic          dst_clk,
  input  logic          dst_rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1_q, stage2_q;

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= gray_in;
      stage2_q <= stage1_q;
    end
  end

  always_comb begin
    bin_out[PW-1] = stage2_q[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ stage2_q[i];
    end
  end
endmodule

// File: rtl/pkt_store.sv
`timescale 1ns/1ps
// Word storage: clocked write port, combinational read port.
module pkt_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_wr_ctrl.sv
`timescale 1ns/1ps
// Write side: splits each measurement into two words and gates filling
// on the occupancy level seen in this domain.
module pkt_wr_ctrl
  import pkt_cap_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int DEPTH   = 1024,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int MEAS_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [MEAS_W-1:0] meas_data,
  input  logic [PW-1:0]     rptr_sync,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [WORD_W-1:0] wdata,
  output logic [PW-1:0]     wptr_gray,
  output logic [PW-1:0]     wptr,
  output logic [PW-1:0]     level,
  output logic              filling,
  output logic              lsw_pend,
  output logic              dropped
);
  wr_state_e         st_q;
  logic [PW-1:0]     wptr_q, wptr_d;
  logic [WORD_W-1:0] lsw_q;
  logic              pend_q, drop_q;
  logic              take;

  // Level is pessimistic: the read pointer copy can only lag.
  assign level   = wptr_q - rptr_sync;
  assign take    = meas_valid && (st_q == W_FILL) && !pend_q &&
                   (level <= PW'(DEPTH - 2));
  assign we      = take || pend_q;
  assign wdata   = pend_q ? lsw_q : meas_data[MEAS_W-1 -: WORD_W];
  assign waddr   = wptr_q[AW-1:0];
  assign wptr_d  = wptr_q + PW'(we);

  assign wptr     = wptr_q;
  assign filling  = (st_q == W_FILL);
  assign lsw_pend = pend_q;
  assign dropped  = drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= W_WAIT_EMPTY;
      wptr_q    <= '0;
      wptr_gray <= '0;
      pend_q    <= 1'b0;
      lsw_q     <= '0;
      drop_q    <= 1'b0;
    end else begin
      wptr_q    <= wptr_d;
      wptr_gray <= wptr_d ^ (wptr_d >> 1);
      pend_q    <= take;
      if (take) lsw_q <= meas_data[WORD_W-1:0];
      if (meas_valid && !take) drop_q <= 1'b1;
      case (st_q)
        W_WAIT_EMPTY: if (level == '0) st_q <= W_FILL;
        W_FILL:       if (level == PW'(DEPTH)) st_q <= W_WAIT_EMPTY;
        default:      st_q <= W_WAIT_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/pkt_rd_ctrl.sv
`timescale 1ns/1ps
// Read side: waits for a complete packet, settles two cycles, then
// drains until the level seen here reaches zero.
module pkt_rd_ctrl
  import pkt_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] wptr_sync,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_gray,
  output logic [PW-1:0] level
);
  rd_state_e     st_q;
  logic [PW-1:0] rptr_q, rptr_d;
  logic          empty;

  // Level is pessimistic: the write pointer copy can only lag.
  assign level  = wptr_sync - rptr_q;
  assign empty  = (level == '0);
  assign valid  = (st_q == R_DRAIN) && !empty;
  assign rptr_d = rptr_q + PW'(valid && ready);
  assign raddr  = rptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= R_IDLE;
      rptr_q    <= '0;
      rptr_gray <= '0;
    end else begin
      rptr_q    <= rptr_d;
      rptr_gray <= rptr_d ^ (rptr_d >> 1);
      case (st_q)
        R_IDLE:  if (level == PW'(DEPTH)) st_q <= R_SETL1;
        R_SETL1: st_q <= R_SETL2;
        R_SETL2: st_q <= R_DRAIN;
        R_DRAIN: if (empty) st_q <= R_IDLE;
        default: st_q <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_capture_buffer.sv
`timescale 1ns/1ps
module pkt_capture_buffer #(
  parameter int WORD_W   = 16,
  parameter int PKT_MEAS = 512,
  localparam int DEPTH   = 2 * PKT_MEAS,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1,
  localparam int MEAS_W  = 2 * WORD_W
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              meas_valid,
  input  logic [MEAS_W-1:0] meas_data,
  output logic              meas_dropped,
  input  logic              rd_clk,
  input  logic              rd_rst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);
  logic              w_we;
  logic [AW-1:0]     w_addr, r_addr;
  logic [WORD_W-1:0] w_data;
  logic [PW-1:0]     w_gray, r_gray, w_sync, r_sync;
  logic [PW-1:0]     w_ptr, w_level, r_level;
  logic              w_fill, w_pend;

  pkt_wr_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst(wr_rst),
    .meas_valid(meas_valid), .meas_data(meas_data),
    .rptr_sync(r_sync),
    .we(w_we), .waddr(w_addr), .wdata(w_data),
    .wptr_gray(w_gray), .wptr(w_ptr), .level(w_level),
    .filling(w_fill), .lsw_pend(w_pend), .dropped(meas_dropped)
  );

  pkt_ptr_cross #(.PW(PW)) u_r2w (
    .dst_clk(wr_clk), .dst_rst(wr_rst), .gray_in(r_gray), .bin_out(r_sync)
  );

  pkt_ptr_cross #(.PW(PW)) u_w2r (
    .dst_clk(rd_clk), .dst_rst(rd_rst), .gray_in(w_gray), .bin_out(w_sync)
  );

  pkt_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .wr_clk(wr_clk), .we(w_we), .waddr(w_addr), .wdata(w_data),
    .raddr(r_addr), .rdata(rd_data)
  );

  pkt_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rd_rst),
    .wptr_sync(w_sync), .ready(rd_ready),
    .valid(rd_valid), .raddr(r_addr),
    .rptr_gray(r_gray), .level(r_level)
  );
endmodule

// File: rtl/pkt_capture_buffer_chk.sv
`timescale 1ns/1ps
module pkt_capture_buffer_chk #(
  parameter int WORD_W   = 16,
  parameter int PKT_MEAS = 512,
  localparam int DEPTH   = 2 * PKT_MEAS,
  localparam int PW      = $clog2(DEPTH) + 1
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic              meas_dropped,
  input logic [PW-1:0]     w_level,
  input logic              w_fill,
  input logic              w_pend,
  input logic [PW-1:0]     w_ptr,
  input logic [PW-1:0]     r_level
);
  assert_no_overfill_R4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    w_level <= PW'(DEPTH));

  assert_lsw_next_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    w_pend |=> (w_ptr == $past(w_ptr) + PW'(1)));

  assert_arm_on_empty_R5: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $rose(w_fill) |-> ($past(w_level) == '0));

  assert_drop_sticky_R9: assert property (@(posedge wr_clk) disable iff (wr_rst)
    meas_dropped |=> meas_dropped);

  assert_start_after_full_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $rose(rd_valid) |-> (($past(r_level, 2) == PW'(DEPTH)) &&
                         ($past(r_level, 3) == PW'(DEPTH))));

  assert_valid_has_data_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_valid |-> (r_level != '0));

  assert_hold_stall_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind pkt_capture_buffer pkt_capture_buffer_chk #(
  .WORD_W(WORD_W), .PKT_MEAS(PKT_MEAS)
) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .meas_dropped(meas_dropped), .w_level(w_level), .w_fill(w_fill),
  .w_pend(w_pend), .w_ptr(w_ptr), .r_level(r_level)
);

// File: tb/test_pkt_capture_buffer.sv
`timescale 1ns/1ps
module test_pkt_capture_buffer;
  localparam int WORD_W   = 16;
  localparam int PKT_MEAS = 4;
  localparam int DEPTH    = 2 * PKT_MEAS;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst = 1'b1, rd_rst = 1'b1;
  logic        meas_valid = 1'b0;
  logic [31:0] meas_data  = '0;
  logic        meas_dropped, rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_data;

  pkt_capture_buffer #(.WORD_W(WORD_W), .PKT_MEAS(PKT_MEAS)) i_pkt_capture_buffer (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .meas_valid(meas_valid),
    .meas_data(meas_data), .meas_dropped(meas_dropped),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  // 250 MHz write clock; read clock 6 ns, offset so edges never coincide.
  always #2 wr_clk = ~wr_clk;
  initial begin
    #1.5;
    forever begin
      rd_clk = ~rd_clk;
      #3;
    end
  end

  int          n_vec = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  bit          armed = 0, drain_go = 0;
  int          wcount = 0, edges = 0;
  int          rdy_mode = 0, stall_cnt = 0;
  logic [15:0] lf = 16'hACE1;
  bit          prev_stall = 0;
  logic [15:0] prev_word = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  // Count read edges after the last word of a packet is stored.
  always @(posedge rd_clk) if (drain_go) edges++;

  // Per-read-cycle reference comparison, away from the active edge.
  always @(negedge rd_clk) begin
    if (!rd_rst) begin
      bit exp_v;
      case (rdy_mode)
        0: rd_ready = 1'b1;
        1: rd_ready = ~rd_ready;
        2: begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          rd_ready = lf[0];
        end
        default: begin
          stall_cnt++;
          rd_ready = (stall_cnt % 9) == 0;
        end
      endcase
      exp_v = drain_go && (edges >= 5) && (exp_q.size() > 0);
      if (prev_stall)
        check(rd_valid && (rd_data == prev_word), "R8 held word",
              {15'd0, rd_valid, rd_data}, {16'd1, prev_word});
      check(rd_valid == exp_v, "R6 R7 rd_valid", 32'(rd_valid), 32'(exp_v));
      prev_stall = 0;
      if (exp_v && rd_valid) begin
        check(rd_data == exp_q[0], "R1 R2 word order", 32'(rd_data), 32'(exp_q[0]));
        if (rd_ready) begin
          void'(exp_q.pop_front());
          if (exp_q.size() == 0) drain_go = 0;
        end else begin
          prev_stall = 1;
          prev_word  = rd_data;
        end
      end
    end
  end

  function automatic logic [31:0] pat(input int k);
    logic [15:0] hi, lo;
    hi = 16'h2A4E + 16'(k * 16'h0111);
    lo = 16'hA400 ^ 16'(k * 16'h0013);
    return {hi, lo};
  endfunction

  task automatic send(input logic [31:0] d);
    bit acc;
    @(negedge wr_clk);
    meas_valid = 1'b1;
    meas_data  = d;
    acc = armed && (wcount + 2 <= DEPTH);
    @(posedge wr_clk);
    @(negedge wr_clk);
    meas_valid = 1'b0;
    if (acc) begin
      exp_q.push_back(d[31:16]);
      exp_q.push_back(d[15:0]);
      wcount += 2;
      if (wcount == DEPTH) begin
        armed = 0;
        @(posedge wr_clk);
        edges    = 0;
        drain_go = 1;
      end
    end
  endtask

  // Two strobes on consecutive cycles: the second meets a pending half.
  task automatic send_pair(input logic [31:0] d1, input logic [31:0] d2);
    @(negedge wr_clk);
    meas_valid = 1'b1;
    meas_data  = d1;
    @(posedge wr_clk);
    @(negedge wr_clk);
    meas_data = d2;
    @(posedge wr_clk);
    @(negedge wr_clk);
    meas_valid = 1'b0;
    exp_q.push_back(d1[31:16]);
    exp_q.push_back(d1[15:0]);
    wcount += 2;
  endtask

  task automatic wait_drained();
    wait (!drain_go);
    repeat (12) @(posedge wr_clk);
    armed  = 1;
    wcount = 0;
  endtask

  task automatic check_idle(input string tag);
    repeat (6) @(negedge rd_clk);
    check(!rd_valid, tag, 32'(rd_valid), 32'd0);
  endtask

  initial begin
    #400_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int k = 0;
    repeat (6) @(posedge wr_clk);
    @(negedge wr_clk);
    check(!rd_valid, "R10 reset rd_valid", 32'(rd_valid), 32'd0);
    check(!meas_dropped, "R10 reset dropped", 32'(meas_dropped), 32'd0);
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    repeat (12) @(posedge wr_clk);
    armed = 1;

    // Packet A: plain, consumer always ready.
    rdy_mode = 0;
    for (int i = 0; i < PKT_MEAS; i++) begin
      send(pat(k++));
      repeat (i) @(posedge wr_clk);
    end
    wait_drained();
    @(negedge wr_clk);
    check(!meas_dropped, "R9 no drop yet", 32'(meas_dropped), 32'd0);

    // Packet B: pause mid-packet (no partial read), then a strobe pair.
    rdy_mode = 1;
    send(pat(k++));
    repeat (60) @(posedge wr_clk);
    check(!rd_valid, "R7 partial packet", 32'(rd_valid), 32'd0);
    send_pair(pat(k), pat(k + 1));
    k += 2;
    @(negedge wr_clk);
    check(meas_dropped, "R3 R9 pair drop", 32'(meas_dropped), 32'd1);
    send(pat(k++));
    send(pat(k++));
    wait_drained();
    check_idle("R3 R4 no extra word");

    // Write reset clears the sticky flag; read reset alongside.
    @(negedge wr_clk);
    wr_rst = 1'b1;
    rd_rst = 1'b1;
    repeat (6) @(posedge wr_clk);
    @(negedge wr_clk);
    check(!meas_dropped, "R10 dropped cleared", 32'(meas_dropped), 32'd0);
    check(!rd_valid, "R10 rd_valid low", 32'(rd_valid), 32'd0);
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    repeat (12) @(posedge wr_clk);
    armed  = 1;
    wcount = 0;

    // Packet C: surplus after full, and offers during the drain.
    rdy_mode = 2;
    for (int i = 0; i < PKT_MEAS; i++) send(pat(k++));
    send(pat(k++));
    @(negedge wr_clk);
    check(meas_dropped, "R4 surplus dropped", 32'(meas_dropped), 32'd1);
    repeat (3) begin
      send(pat(k++));
      repeat (5) @(posedge wr_clk);
    end
    wait_drained();
    check_idle("R4 R5 no late word");

    // Packets D and E: long stalls, then random; pointers wrap.
    rdy_mode = 3;
    for (int i = 0; i < PKT_MEAS; i++) send(pat(k++));
    wait_drained();
    rdy_mode = 2;
    for (int i = 0; i < PKT_MEAS; i++) send(pat(k++));
    wait_drained();
    check_idle("R5 R7 idle after drain");
    check(exp_q.size() == 0, "R2 all words out", 32'(exp_q.size()), 32'd0);

    summary();
    $finish;
  end
endmodule